// File: doc/BRIEF.md
# Destination Address Receive Filter

This block sits in the receive path of an Ethernet MAC. It decides, frame by frame, whether a frame is kept or dropped. It watches the byte stream from the start-of-frame marker and collects the first six bytes as the 48-bit destination address. While those bytes arrive it also runs a CRC-32 over them to form a 6-bit index into a 64-bit multicast hash table. Once the sixth byte has been taken, it compares the address with the station address and classifies the frame as broadcast, multicast or neither. It then applies a two-bit filter mode to produce one accept decision.

Along with the decision it drives four flags that the receive status word records: physical address match, multicast filter match, broadcast and multicast. It also keeps one sticky bit holding the most recent hash-table lookup. That bit is updated only while reception is enabled. Everything after the address, including CRC checking of the frame and buffering, belongs to other blocks.

Top module: `rx_da_filter`

## Requirements
- R1: With `filt_mode` = 2'b00, `accept` is 1 only when the destination equals `station_addr`.
- R2: With `filt_mode` = 2'b01, `accept` is 1 when any of these holds: the destination matches the station address, the frame is broadcast, or the frame is multicast and its hash-table bit is 1.
- R3: With `filt_mode` = 2'b10, `accept` is 1 for a station match, for broadcast, and for every multicast frame, whatever the hash table holds.
- R4: With `filt_mode` = 2'b11, `accept` is 1 for every frame.
- R5: The first destination byte on the wire is `station_addr[7:0]` and byte i is `[8i+7:8i]`. `bcast_seen` is 1 when all 48 bits are ones. `mcast_seen` is 1 when bit 0 of the first byte is 1 and the frame is not broadcast.
- R6: The hash index is computed with a reflected CRC-32: polynomial 32'hEDB88320, initial value 32'hFFFFFFFF, no final inversion, taken over the six destination bytes, least significant bit first. The index is bits [31:26] of that CRC and selects `hash_table[index]`. `mcast_filt_match` is 1 when `mcast_seen` is 1 and the selected bit is 1.
- R7: `phys_match` reports whether the destination equals the station address, whatever the mode.
- R8: `result_valid` and the flags rise in the cycle after the sixth byte is taken. Before that they are 0. They hold their values until a new start-of-frame byte is taken, and they are cleared in the cycle after it.
- R9: Bytes that arrive after the sixth one, before the next start-of-frame, leave every output unchanged.
- R10: When the sixth byte is taken while `rx_en` is 1, `hash_bit_latched` loads the selected hash-table bit. While `rx_en` is 0 it keeps its value.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates the hash-bit latch |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| sof | input | 1 | Marks the byte as the first byte of a frame |
| byte_data | input | 8 | Frame byte |
| station_addr | input | 48 | Station physical address, first wire byte in [7:0] |
| hash_table | input | 64 | Multicast hash table |
| filt_mode | input | 2 | Filter mode (00 own, 01 hash, 10 all multicast, 11 promiscuous) |
| result_valid | output | 1 | Decision and flags are valid |
| accept | output | 1 | Frame is accepted |
| phys_match | output | 1 | Destination equals station address |
| mcast_filt_match | output | 1 | Multicast frame that hit the hash table |
| bcast_seen | output | 1 | Broadcast destination |
| mcast_seen | output | 1 | Multicast destination (broadcast excluded) |
| hash_bit_latched | output | 1 | Last hash-table bit selected while enabled |

## Verification
Five destination classes are sent under each of the four modes: own address, broadcast, multicast with its hash bit set, multicast with its hash bit cleared, and a foreign unicast. Between them these separate every rung of the mode ladder from its neighbours. Random multicast addresses against random hash tables test the CRC index, because a wrong index or bit order flips the filter-match flag. Trailing bytes after the address, idle gaps, and frames sent with receive enabled and then disabled test the hold, ignore and latch rules.

// File: rtl/rxf_pkg.sv
// Shared types and the CRC-32 byte step for the destination address filter.
// Assumes reflected CRC-32, consumed least significant bit first.
package rxf_pkg;

    typedef enum logic [1:0] {
        FM_OWN     = 2'b00,
        FM_HASH    = 2'b01,
        FM_ALLMC   = 2'b10,
        FM_PROMISC = 2'b11
    } filt_mode_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // Advance a reflected CRC-32 by one byte, LSB of the byte first.
    function automatic logic [31:0] crc32_step_byte(input logic [31:0] crc_in,
                                                    input logic [7:0]  din);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ din[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
// Collects the first ADDR_BYTES bytes of a frame into an address register.
// Also gives a live view of the address in which the byte now on the input
// is already placed, so the decision can be registered on the last byte.
// Assumes sof arrives together with byte_valid on the first byte.
module rxf_addr_capture #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic                    sof,
    input  logic [7:0]              byte_data,
    output logic                    take_byte,
    output logic                    first_byte,
    output logic                    last_byte,
    output logic [8*ADDR_BYTES-1:0] addr_live
);
    localparam int CW = $clog2(ADDR_BYTES + 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic [CW-1:0] cur_idx;

    // Byte position of the current input and whether it belongs to the address.
    always_comb begin
        cur_idx    = sof ? '0 : cnt_q;
        first_byte = byte_valid && sof;
        take_byte  = byte_valid && (sof || active_q);
        last_byte  = take_byte && (cur_idx == CW'(ADDR_BYTES - 1));
    end

    // Track progress through the address field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (take_byte) begin
            cnt_q    <= cur_idx + CW'(1);
            active_q <= (cur_idx != CW'(ADDR_BYTES - 1));
        end
    end

    generate
        for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
            logic [7:0] lane_q;
            logic       hit;
            assign hit = take_byte && (cur_idx == CW'(g));
            // Store this byte lane when its position arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)   lane_q <= '0;
                else if (hit) lane_q <= byte_data;
            end
            assign addr_live[8*g +: 8] = hit ? byte_data : lane_q;
        end
    endgenerate

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(ADDR_BYTES));

    p_done_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && !first_byte) |=> !active_q);

endmodule

// File: rtl/rxf_hash_crc.sv
// Runs a reflected CRC-32 over the address bytes as they arrive and gives the
// multicast hash index from the upper CRC bits, including the current byte.
// Assumes take_byte/first_byte come from the address capture stage.
module rxf_hash_crc #(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_byte,
    input  logic                 first_byte,
    input  logic [7:0]           byte_data,
    output logic [HASH_BITS-1:0] hash_idx
);
    import rxf_pkg::*;

    logic [31:0] crc_q;
    logic [31:0] crc_next;

    // Seed on the first byte, otherwise continue from the stored remainder.
    always_comb begin
        crc_next = crc32_step_byte(first_byte ? 32'hFFFF_FFFF : crc_q, byte_data);
        hash_idx = crc_next[31 -: HASH_BITS];
    end

    // Keep the running remainder between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= 32'hFFFF_FFFF;
        else if (take_byte) crc_q <= crc_next;
    end

    p_crc_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_byte |=> $stable(crc_q));

endmodule

// File: rtl/rxf_decide.sv
// Classifies the captured address, applies the filter mode and registers the
// decision and status flags on the last address byte; clears on a new frame.
// Assumes addr_live and hash_idx already include the byte on the input.
module rxf_decide #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    first_byte,
    input  logic                    last_byte,
    input  logic [8*ADDR_BYTES-1:0] addr_live,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic [(1<<HASH_BITS)-1:0] hash_table,
    input  logic [HASH_BITS-1:0]    hash_idx,
    input  logic [1:0]              filt_mode,
    output logic                    result_valid,
    output logic                    accept,
    output logic                    phys_match,
    output logic                    mcast_filt_match,
    output logic                    bcast_seen,
    output logic                    mcast_seen,
    output logic                    hash_bit_latched
);
    import rxf_pkg::*;

    logic phys_c, bcast_c, mcast_c, hit_c, mfilt_c, accept_c;

    // Address classes, hash lookup and the mode ladder.
    always_comb begin
        phys_c  = (addr_live == station_addr);
        bcast_c = &addr_live;
        mcast_c = addr_live[0] && !bcast_c;
        hit_c   = hash_table[hash_idx];
        mfilt_c = mcast_c && hit_c;
        unique case (filt_mode_e'(filt_mode))
            FM_OWN:     accept_c = phys_c;
            FM_HASH:    accept_c = phys_c || bcast_c || mfilt_c;
            FM_ALLMC:   accept_c = phys_c || bcast_c || mcast_c;
            FM_PROMISC: accept_c = 1'b1;
            default:    accept_c = 1'b0;
        endcase
    end

    // Register the decision on the last byte, drop it when a new frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n || (first_byte && !last_byte)) begin
            result_valid     <= 1'b0;
            accept           <= 1'b0;
            phys_match       <= 1'b0;
            mcast_filt_match <= 1'b0;
            bcast_seen       <= 1'b0;
            mcast_seen       <= 1'b0;
        end else if (last_byte) begin
            result_valid     <= 1'b1;
            accept           <= accept_c;
            phys_match       <= phys_c;
            mcast_filt_match <= mfilt_c;
            bcast_seen       <= bcast_c;
            mcast_seen       <= mcast_c;
        end
    end

    // Sticky copy of the hash-select output while receive is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hash_bit_latched <= 1'b0;
        else if (last_byte && rx_en) hash_bit_latched <= hit_c;
    end

    p_mfilt_needs_mcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mcast_filt_match |-> mcast_seen);

    p_bc_mc_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bcast_seen && mcast_seen));

    p_own_accepted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && phys_match) |-> accept);

    p_clear_after_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_byte && !last_byte) |=> !result_valid);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> !(accept || phys_match || bcast_seen || mcast_seen));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !first_byte) |=>
            (result_valid && $stable(accept) && $stable(phys_match) &&
             $stable(mcast_filt_match) && $stable(bcast_seen) && $stable(mcast_seen)));

    p_latch_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(hash_bit_latched));

endmodule

// File: rtl/rx_da_filter.sv
// Destination address receive filter: address capture, CRC hash index and
// the accept decision with its status flags. Synchronous active-low reset.
// Assumes one byte per cycle at most and sof only on a frame's first byte.
module rx_da_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        byte_valid,
    input  logic        sof,
    input  logic [7:0]  byte_data,
    input  logic [47:0] station_addr,
    input  logic [63:0] hash_table,
    input  logic [1:0]  filt_mode,
    output logic        result_valid,
    output logic        accept,
    output logic        phys_match,
    output logic        mcast_filt_match,
    output logic        bcast_seen,
    output logic        mcast_seen,
    output logic        hash_bit_latched
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int TW = 1 << HASH_BITS;

    logic                 take_byte, first_byte, last_byte;
    logic [AW-1:0]        addr_live;
    logic [HASH_BITS-1:0] hash_idx;

    rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .sof        (sof),
        .byte_data  (byte_data),
        .take_byte  (take_byte),
        .first_byte (first_byte),
        .last_byte  (last_byte),
        .addr_live  (addr_live)
    );

    rxf_hash_crc #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_byte  (take_byte),
        .first_byte (first_byte),
        .byte_data  (byte_data),
        .hash_idx   (hash_idx)
    );

    rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dec (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_en            (rx_en),
        .first_byte       (first_byte),
        .last_byte        (last_byte),
        .addr_live        (addr_live),
        .station_addr     (station_addr[AW-1:0]),
        .hash_table       (hash_table[TW-1:0]),
        .hash_idx         (hash_idx),
        .filt_mode        (filt_mode),
        .result_valid     (result_valid),
        .accept           (accept),
        .phys_match       (phys_match),
        .mcast_filt_match (mcast_filt_match),
        .bcast_seen       (bcast_seen),
        .mcast_seen       (mcast_seen),
        .hash_bit_latched (hash_bit_latched)
    );

    p_valid_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> result_valid);

endmodule

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b1;
    logic        byte_valid = 1'b0;
    logic        sof = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] station = 48'h6655_4433_2210;
    logic [63:0] htab = '0;
    logic [1:0]  mode = 2'b00;
    logic        result_valid, accept, phys_match, mcast_filt_match;
    logic        bcast_seen, mcast_seen, hash_bit_latched;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    rx_da_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .byte_valid(byte_valid),
        .sof(sof), .byte_data(byte_data), .station_addr(station),
        .hash_table(htab), .filt_mode(mode), .result_valid(result_valid),
        .accept(accept), .phys_match(phys_match),
        .mcast_filt_match(mcast_filt_match), .bcast_seen(bcast_seen),
        .mcast_seen(mcast_seen), .hash_bit_latched(hash_bit_latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // Bit-serial CRC over the 48 destination bits, wire order = bit 0 first.
    function automatic logic [5:0] exp_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ a[i];
            c = (c >> 1) ^ (32'hEDB88320 & {32{fb}});
        end
        return c[31:26];
    endfunction

    task automatic send_da(input logic [47:0] a, input int extra);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 2) chk("R8", "valid before address done", result_valid, 1'b0);
            byte_valid = 1'b1;
            sof        = (i == 0);
            byte_data  = a[8*i +: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        sof        = 1'b0;
        for (int e = 0; e < extra; e++) begin
            byte_valid = 1'b1;
            byte_data  = rnd()[7:0];
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic check_frame(input logic [47:0] a, input int extra, input string tag);
        logic ph, bc, mc, hit, mf, acc;
        ph  = (a == station);
        bc  = &a;
        mc  = a[0] && !bc;
        hit = htab[exp_idx(a)];
        mf  = mc && hit;
        case (mode)
            2'b00:   acc = ph;
            2'b01:   acc = ph || bc || mf;
            2'b10:   acc = ph || bc || mc;
            default: acc = 1'b1;
        endcase
        send_da(a, extra);
        chk(tag, "result_valid", result_valid, 1'b1);
        case (mode)
            2'b00:   chk("R1", {tag, " accept"}, accept, acc);
            2'b01:   chk("R2", {tag, " accept"}, accept, acc);
            2'b10:   chk("R3", {tag, " accept"}, accept, acc);
            default: chk("R4", {tag, " accept"}, accept, acc);
        endcase
        chk("R7", {tag, " phys_match"}, phys_match, ph);
        chk("R5", {tag, " bcast"}, bcast_seen, bc);
        chk("R5", {tag, " mcast"}, mcast_seen, mc);
        chk("R6", {tag, " mcast_filt"}, mcast_filt_match, mf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        repeat (3) @(negedge clk);
        chk("R11", "outputs in reset",
            {result_valid, accept, phys_match, mcast_filt_match,
             bcast_seen, mcast_seen, hash_bit_latched}, '0);
        rst_n = 1'b1;

        // Five destination classes under each mode.
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            htab = 64'h0123_4567_89AB_CDEF;
            check_frame(station, 0, "R8 own");
            check_frame(48'hFFFF_FFFF_FFFF, 0, "R8 bcast");
            a    = 48'h0A0B_0C0D_0E01;
            ix   = exp_idx(a);
            htab = 64'd1 << ix;
            check_frame(a, 0, "R8 mc-hit");
            htab = ~(64'd1 << ix);
            check_frame(a, 0, "R8 mc-miss");
            check_frame(48'h6655_4433_2212, 0, "R8 unicast");
            check_frame(48'h7655_4433_2210, 0, "R8 near-own");
        end

        // Random multicast addresses against random tables.
        for (int k = 0; k < 48; k++) begin
            mode = 2'(k % 4);
            htab = {rnd(), rnd()};
            a    = {rnd()[15:0], rnd()} | 48'h1;
            check_frame(a, 0, "R6 rand");
        end

        // Trailing bytes and idle time leave outputs unchanged.
        mode = 2'b01;
        a    = 48'h0102_0304_0503;
        htab = 64'd1 << exp_idx(a);
        check_frame(a, 5, "R9 trailing");
        repeat (7) @(negedge clk);
        chk("R8", "hold after idle accept", accept, 1'b1);
        chk("R8", "hold after idle valid", result_valid, 1'b1);

        // New sof clears the old decision one cycle later.
        @(negedge clk);
        byte_valid = 1'b1; sof = 1'b1; byte_data = 8'h00;
        @(negedge clk);
        byte_valid = 1'b0; sof = 1'b0;
        chk("R8", "cleared after sof", {result_valid, accept}, 2'b00);

        // Hash latch follows rx_en.
        rx_en = 1'b1;
        htab  = '1;
        check_frame(48'h1111_2222_3333, 0, "R10 en");
        chk("R10", "latched with rx_en", hash_bit_latched, 1'b1);
        rx_en = 1'b0;
        htab  = '0;
        check_frame(48'h1111_2222_3335, 0, "R10 dis");
        chk("R10", "frozen without rx_en", hash_bit_latched, 1'b1);
        rx_en = 1'b1;
        check_frame(48'h1111_2222_3337, 0, "R10 re-en");
        chk("R10", "latched again", hash_bit_latched, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule